// File: doc/BRIEF.md
# Exception Vector Fetch Watcher

This block watches the instruction fetch stream of a processor core and raises a debug event when the core fetches from an exception vector that software has armed. An 8-bit catch mask, written through a simple register write port and readable back, selects the vectors being watched. Each mask bit maps to one exception vector. Software clears or sets bits to choose which exception entries stop the core.

The address watched for each armed bit follows the exception vector configuration of the core. A high-vectors select moves the whole table from the bottom of the address space to the top. A vectored-interrupt enable makes the IRQ and FIQ catches watch the handler addresses the core most recently jumped to when taking those interrupts, and not the fixed table slots. The block captures those handler addresses from take strobes issued by the core.

On a match the block gives a registered pulse that is one clock wide. The pulse comes with a code that gives the index of the catch bit that fired.

Top module: `dbg_vector_catch`

## Requirements
- R1: After reset the catch mask reads 0x00000000, no event pulse is raised, and both captured handler addresses are 0x00000000.
- R2: A write stores only mask bits 0 to 4, 6 and 7. Bit 5 and bits 31:8 are dropped on write and always read back as zero (writable mask 0x000000DF).
- R3: With high vectors off, bits 0 to 4 watch addresses 0x00, 0x04, 0x08, 0x0C and 0x10 (Reset, Undefined, SVC, Prefetch Abort, Data Abort). The reported code equals the bit index.
- R4: With high vectors on, every table slot moves to base 0xFFFF0000 plus the same offset. The low-table address no longer matches.
- R5: With vectored interrupts off, bit 6 (IRQ) watches base+0x18 and bit 7 (FIQ) watches base+0x1C, following the high-vectors select. Offset 0x14 matches nothing.
- R6: With vectored interrupts on, bits 6 and 7 watch the captured IRQ and FIQ handler addresses regardless of the high-vectors select. Their fixed slots no longer match, and bits 0 to 4 still follow the select.
- R7: Each handler address is captured on the clock edge where its own take strobe is high. It holds until the next take.
- R8: An event requires the fetch valid strobe, the armed mask bit and exact equality on all address bits. A fetch with valid low or to a disarmed vector raises nothing.
- R9: The event pulse is registered. It appears in the cycle after the matching fetch and lasts one clock per matching fetch.
- R10: When several armed catches match one fetch, the lowest bit index is reported.
- R11: A mask write, or a change of the high-vectors or vectored-interrupt inputs, applies to the very next fetch with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Catch mask write strobe |
| ctl_wr_data | input | 32 | Catch mask write value |
| ctl_rd_data | output | 32 | Catch mask readback |
| hivec_sel | input | 1 | High exception vector table select |
| vec_irq_en | input | 1 | Vectored-interrupt enable |
| irq_take | input | 1 | IRQ taken, capture handler address |
| irq_handler_addr | input | ADDR_W | IRQ handler address |
| fiq_take | input | 1 | FIQ taken, capture handler address |
| fiq_handler_addr | input | ADDR_W | FIQ handler address |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| event_pulse | output | 1 | Vector catch debug event |
| event_code | output | 3 | Index of the catch bit that fired |

## Verification
The bench builds the block with its default 32-bit address width and high table base 0xFFFF0000. These defaults make the full-width equality testable at both ends of the address space: a high-table slot and its low-table alias differ only in the upper half-word. With these values a handler address of zero can also collide with the Reset slot, which brings the lowest-index priority rule into play.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
    localparam int NCATCH   = 8;
    localparam int CODE_W   = $clog2(NCATCH);
    localparam int CTL_W    = 32;
    localparam logic [CTL_W-1:0] CTL_MASK = 32'h0000_00DF;
    localparam int IRQ_IDX  = 6;
    localparam int FIQ_IDX  = 7;
    localparam int SLOT_STEP = 4;

    typedef struct packed {
        logic              pulse;
        logic [CODE_W-1:0] code;
    } evt_t;
endpackage

// File: rtl/vc_ctrl_reg.sv
module vc_ctrl_reg
    import vcatch_pkg::*;
#(
    parameter int W = CTL_W,
    parameter logic [W-1:0] MASK = CTL_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctl_q
);
    logic [W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_data & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R2: a write stores the masked value
    a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (ctl_q == ($past(wr_data) & MASK)));
    // R2: without a write the mask holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(ctl_q));
endmodule

// File: rtl/vc_handler_latch.sv
module vc_handler_latch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_q
);
    logic [AW-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (take) begin
            addr_d = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R7: capture on take, hold otherwise
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> (addr_q == $past(addr)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take) |-> $stable(addr_q));
endmodule

// File: rtl/vc_match.sv
module vc_match
    import vcatch_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic [NCATCH-1:0] arm,
    input  logic              hivec_sel,
    input  logic              vec_irq_en,
    input  logic [AW-1:0]     irq_addr,
    input  logic [AW-1:0]     fiq_addr,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    logic [AW-1:0]     base;
    logic [NCATCH-1:0] hits;

    assign base = hivec_sel ? HI_BASE : '0;

    for (genvar i = 0; i < NCATCH; i++) begin : g_slot
        logic [AW-1:0] tgt;
        if (i == IRQ_IDX) begin : g_irq
            assign tgt = vec_irq_en ? irq_addr : base + AW'(i * SLOT_STEP);
        end else if (i == FIQ_IDX) begin : g_fiq
            assign tgt = vec_irq_en ? fiq_addr : base + AW'(i * SLOT_STEP);
        end else begin : g_fixed
            assign tgt = base + AW'(i * SLOT_STEP);
        end
        assign hits[i] = fetch_valid && arm[i] && (fetch_addr == tgt);
    end

    always_comb begin
        code = '0;
        for (int i = NCATCH - 1; i >= 0; i--) begin
            if (hits[i]) code = CODE_W'(i);
        end
    end

    assign hit = |hits;
endmodule

// File: rtl/dbg_vector_catch.sv
module dbg_vector_catch
    import vcatch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    output logic [CTL_W-1:0]  ctl_rd_data,
    input  logic              hivec_sel,
    input  logic              vec_irq_en,
    input  logic              irq_take,
    input  logic [ADDR_W-1:0] irq_handler_addr,
    input  logic              fiq_take,
    input  logic [ADDR_W-1:0] fiq_handler_addr,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              event_pulse,
    output logic [CODE_W-1:0] event_code
);
    logic [CTL_W-1:0]  ctl_q;
    logic [ADDR_W-1:0] irq_q, fiq_q;
    logic              hit;
    logic [CODE_W-1:0] hit_code;
    evt_t              evt_d, evt_q;

    vc_ctrl_reg #(.W(CTL_W), .MASK(CTL_MASK)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
        .wr_data(ctl_wr_data), .ctl_q(ctl_q)
    );

    vc_handler_latch #(.AW(ADDR_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .take(irq_take),
        .addr(irq_handler_addr), .addr_q(irq_q)
    );

    vc_handler_latch #(.AW(ADDR_W)) u_fiq (
        .clk(clk), .rst_n(rst_n), .take(fiq_take),
        .addr(fiq_handler_addr), .addr_q(fiq_q)
    );

    vc_match #(.AW(ADDR_W), .HI_BASE(HI_BASE)) u_match (
        .arm(ctl_q[NCATCH-1:0]), .hivec_sel(hivec_sel),
        .vec_irq_en(vec_irq_en), .irq_addr(irq_q), .fiq_addr(fiq_q),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .hit(hit), .code(hit_code)
    );

    always_comb begin
        evt_d       = '0;
        evt_d.pulse = hit;
        if (hit) evt_d.code = hit_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign ctl_rd_data = ctl_q;
    assign event_pulse = evt_q.pulse;
    assign event_code  = evt_q.code;

    // R8: an event needs a valid fetch in the previous cycle
    a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> $past(fetch_valid));
    // R8: the reported bit was armed when the fetch was seen
    a_r8_armed: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> ((($past(ctl_rd_data)) >> event_code) & 32'd1) != 32'd0);
    // R2: reserved mask bits never read as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_data & ~CTL_MASK) == '0);
    // R9: no fetch last cycle means no pulse now
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch_valid) |-> !event_pulse);
endmodule

// File: tb/sim_dbg_vector_catch.sv
module sim_dbg_vector_catch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        hivec_sel = 1'b0;
    logic        vec_irq_en = 1'b0;
    logic        irq_take = 1'b0;
    logic [31:0] irq_handler_addr = '0;
    logic        fiq_take = 1'b0;
    logic [31:0] fiq_handler_addr = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        event_pulse;
    logic [2:0]  event_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dbg_vector_catch u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .hivec_sel(hivec_sel), .vec_irq_en(vec_irq_en),
        .irq_take(irq_take), .irq_handler_addr(irq_handler_addr),
        .fiq_take(fiq_take), .fiq_handler_addr(fiq_handler_addr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .event_pulse(event_pulse), .event_code(event_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic take_irq(input logic [31:0] a);
        @(negedge clk);
        irq_take = 1'b1; irq_handler_addr = a;
        @(negedge clk);
        irq_take = 1'b0;
    endtask

    task automatic take_fiq(input logic [31:0] a);
        @(negedge clk);
        fiq_take = 1'b1; fiq_handler_addr = a;
        @(negedge clk);
        fiq_take = 1'b0;
    endtask

    // drive a fetch for one cycle, check the registered result one edge later
    task automatic fetch_chk(input string req, input logic [31:0] a, input logic vld,
                             input logic exp_hit, input logic [2:0] exp_code);
        fetch_valid = vld; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(req, {31'd0, event_pulse}, {31'd0, exp_hit});
        if (exp_hit) chk(req, {29'd0, event_code}, {29'd0, exp_code});
    endtask

    task automatic t_reset();
        chk("R1 mask", ctl_rd_data, 32'h0);
        chk("R1 pulse", {31'd0, event_pulse}, 32'h0);
        // R7 / R1: captured IRQ address starts at zero
        wr_ctl(32'h40); vec_irq_en = 1'b1;
        fetch_chk("R1 irq latch zero", 32'h0, 1'b1, 1'b1, 3'd6);
        vec_irq_en = 1'b0; wr_ctl(32'h0);
    endtask

    task automatic t_mask();
        wr_ctl(32'hFFFF_FFFF);
        chk("R2 readback", ctl_rd_data, 32'h0000_00DF);
        wr_ctl(32'h0000_0020);
        chk("R2 bit5 dropped", ctl_rd_data, 32'h0);
    endtask

    task automatic t_low();
        wr_ctl(32'hFF); hivec_sel = 1'b0; vec_irq_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) fetch_chk("R3 low slot", 32'(i * 4), 1'b1, 1'b1, 3'(i));
        fetch_chk("R5 slot 0x14 unused", 32'h14, 1'b1, 1'b0, 3'd0);
        fetch_chk("R5 irq low", 32'h18, 1'b1, 1'b1, 3'd6);
        fetch_chk("R5 fiq low", 32'h1C, 1'b1, 1'b1, 3'd7);
        fetch_chk("R9 no repeat", 32'h0, 1'b0, 1'b0, 3'd0);
        fetch_chk("R8 off-vector", 32'h20, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_high();
        hivec_sel = 1'b1;
        fetch_chk("R4 high svc", 32'hFFFF_0008, 1'b1, 1'b1, 3'd2);
        fetch_chk("R4 low alias", 32'h0000_0008, 1'b1, 1'b0, 3'd0);
        fetch_chk("R5 fiq high", 32'hFFFF_001C, 1'b1, 1'b1, 3'd7);
        hivec_sel = 1'b0;
    endtask

    task automatic t_gate();
        wr_ctl(32'h01);
        fetch_chk("R8 disarmed", 32'h04, 1'b1, 1'b0, 3'd0);
        fetch_chk("R8 valid low", 32'h00, 1'b0, 1'b0, 3'd0);
        fetch_chk("R8 armed", 32'h00, 1'b1, 1'b1, 3'd0);
    endtask

    task automatic t_vectored();
        take_irq(32'h1234_5600);
        take_fiq(32'h0000_8000);
        wr_ctl(32'hDF); vec_irq_en = 1'b1; hivec_sel = 1'b1;
        fetch_chk("R6 irq handler", 32'h1234_5600, 1'b1, 1'b1, 3'd6);
        fetch_chk("R7 fiq handler", 32'h0000_8000, 1'b1, 1'b1, 3'd7);
        fetch_chk("R6 fixed irq gone", 32'hFFFF_0018, 1'b1, 1'b0, 3'd0);
        fetch_chk("R6 others follow", 32'hFFFF_0004, 1'b1, 1'b1, 3'd1);
        hivec_sel = 1'b0;
        fetch_chk("R6 ignores select", 32'h1234_5600, 1'b1, 1'b1, 3'd6);
    endtask

    task automatic t_priority();
        take_irq(32'h0);
        wr_ctl(32'h41); vec_irq_en = 1'b1; hivec_sel = 1'b0;
        fetch_chk("R10 lowest wins", 32'h0, 1'b1, 1'b1, 3'd0);
        wr_ctl(32'h40);
        fetch_chk("R10 irq alone", 32'h0, 1'b1, 1'b1, 3'd6);
    endtask

    task automatic t_latency();
        vec_irq_en = 1'b0;
        wr_ctl(32'h02);
        fetch_chk("R11 mask next fetch", 32'h04, 1'b1, 1'b1, 3'd1);
        hivec_sel = 1'b1;
        fetch_chk("R11 select same cycle", 32'hFFFF_0004, 1'b1, 1'b1, 3'd1);
        wr_ctl(32'h80); hivec_sel = 1'b0; vec_irq_en = 1'b1;
        fetch_chk("R11 vectored same cycle", 32'h0000_8000, 1'b1, 1'b1, 3'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_low();
        t_high();
        t_gate();
        t_vectored();
        t_priority();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule